// File: doc/BRIEF.md
# Read Termination Scheduler

This block sits on the controller side of a DDR3-class memory interface and drives the on-die termination pin of one rank around read bursts. The device cannot terminate the bus while it is driving read data. The scheduler therefore pulls the pin low early enough for termination to be off before the read preamble. It lets the pin rise again only when termination will come back after the postamble. The pin timing is derived from the additive latency, CAS latency and CAS write latency. It is not a fixed delay.

The command path announces each read one cycle ahead on `rd_next`. The read itself then occupies the following cycle, called the read cycle, or offset 0. Because of this advance notice, a window that would start before the read cycle is clamped to start in the read cycle. Each read opens a low window on the pin. The windows of overlapping reads merge, so the pin never rises between them. When no window is active the pin rests at the level chosen by `rest_on`. The block also reports the read latency and the termination latency it derived from the configuration. The configuration is expected to change only while no read is in flight.

Top module: `odt_read_sched`

## Requirements
- R1: `rl` equals `cfg_al + cfg_cl` at all times. For AL=5, CL=6 it reads 11.
- R2: `odtl` equals `cfg_cwl + cfg_al - 2` at all times. For CWL=5, AL=5 it reads 8.
- R3: While `rst_n` is low, `odt` is low.
- R4: A read at offset 0, with CL > CWL, drives `odt` low from offset CL-CWL.
- R5: When CL <= CWL, the low window starts at offset 0, the read cycle itself.
- R6: After a lone read, `odt` is high again at offset CL-CWL+7 when `rest_on` is high. It is low through offset CL-CWL+6.
- R7: With several reads, `odt` is low in every cycle that lies inside any read's window. No high cycle appears between windows that overlap or touch.
- R8: Outside all windows, `odt` in a cycle equals the `rest_on` value sampled at that cycle's opening edge.
- R9: When `rest_on` was low at the opening edge of a cycle, `odt` is low in that cycle, whatever the reads.
- R10: For every read, the pin is low over the window from offset RL-2-ODTLoff through offset RL+4-ODTLon, clamped at offset 0. Termination is therefore off from half a cycle before the preamble until the postamble ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_al | input | CFG_W | Additive latency in cycles |
| cfg_cl | input | CFG_W | CAS read latency in cycles |
| cfg_cwl | input | CFG_W | CAS write latency in cycles |
| rd_next | input | 1 | A read is issued in the next cycle |
| rest_on | input | 1 | Pin level when no read window is active (1 = terminate) |
| odt | output | 1 | Termination control pin for the rank |
| rl | output | CFG_W+1 | Derived read latency |
| odtl | output | CFG_W+1 | Derived termination on/off latency |

## Verification
Two events can fall in the same cycle. One read's window can close in exactly the cycle where the next read's window opens. The idle-level input can also change in the cycle where the last window closes. The bench provokes the first with reads spaced at exactly the window length and at every shorter spacing. It provokes the second with random toggles of `rest_on` during random read traffic. Each cycle, the pin is compared against a bench model built from the union of windows and the sampled idle level. A separate coverage check also derives the required off span of every read from RL, ODTLoff and ODTLon.

// File: rtl/odt_read_sched.sv
module odt_read_sched #(
  parameter int CFG_W = 5,
  parameter int HIST  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_al,
  input  logic [CFG_W-1:0] cfg_cl,
  input  logic [CFG_W-1:0] cfg_cwl,
  input  logic             rd_next,
  input  logic             rest_on,
  output logic             odt,
  output logic [CFG_W:0]   rl,
  output logic [CFG_W:0]   odtl
);

  localparam int SW = $clog2(HIST + 1);

  assign rl   = {1'b0, cfg_al} + {1'b0, cfg_cl};
  assign odtl = {1'b0, cfg_cwl} + {1'b0, cfg_al} - (CFG_W+1)'(2);

  int gap, off_k, on_k;
  always_comb begin
    gap   = int'(cfg_cl) - int'(cfg_cwl);
    off_k = (gap < 0) ? 0 : gap;
    on_k  = gap + 7;
    if (on_k < 1)    on_k = 1;
    if (on_k > HIST) on_k = HIST;
  end

  logic [HIST-2:0] hist;
  logic [HIST-1:0] hist_n, mask;
  assign hist_n = {hist, rd_next};

  for (genvar i = 0; i < HIST; i++) begin : g_mask
    assign mask[i] = (i >= off_k) && (i < on_k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
      odt  <= 1'b0;
    end else begin
      hist <= hist_n[HIST-2:0];
      odt  <= rest_on & ~|(hist_n & mask);
    end
  end

  // cycles since the latest read, kept apart from the history vector
  logic [SW-1:0] since;
  always_ff @(posedge clk) begin
    if (!rst_n)                since <= SW'(HIST);
    else if (rd_next)          since <= '0;
    else if (since != SW'(HIST)) since <= since + 1'b1;
  end

  AST_WINDOW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(since) >= off_k && int'(since) < on_k) |-> !odt); // R7
  AST_CLAMP_START: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_next && cfg_cl <= cfg_cwl) |=> !odt); // R5
  AST_REST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !rest_on |=> !odt); // R9
  AST_RISE_NEEDS_REST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(odt) |-> $past(rest_on)); // R8

endmodule

// File: tb/test_odt_read_sched.sv
`timescale 1ns/1ps
module test_odt_read_sched;
  localparam int CFG_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CFG_W-1:0] cfg_al = 5, cfg_cl = 6, cfg_cwl = 5;
  logic rd_next = 1'b0, rest_on = 1'b1;
  logic odt;
  logic [CFG_W:0] rl, odtl;

  odt_read_sched #(.CFG_W(CFG_W), .HIST(32)) i_odt_read_sched (
    .clk(clk), .rst_n(rst_n), .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_cwl(cfg_cwl),
    .rd_next(rd_next), .rest_on(rest_on), .odt(odt), .rl(rl), .odtl(odtl));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int reads[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic bit model_low(int n);
    int d = int'(cfg_cl) - int'(cfg_cwl);
    int lo = (d < 0) ? 0 : d;
    int hi = d + 7;
    foreach (reads[k]) if (n - reads[k] >= lo && n - reads[k] < hi) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit must_low(int n);
    int rlat = int'(cfg_al) + int'(cfg_cl);
    int tl   = int'(cfg_cwl) + int'(cfg_al) - 2;
    foreach (reads[k]) begin
      int lo = reads[k] + rlat - 2 - tl;
      int hi = reads[k] + rlat + 4 - tl;
      if (lo < reads[k]) lo = reads[k];
      if (n >= lo && n <= hi) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic step(input bit rd, input bit rest);
    bit exp;
    rd_next = rd;
    rest_on = rest;
    @(posedge clk);
    @(negedge clk);
    if (rd) reads.push_back(cyc);
    while (reads.size() > 0 && cyc - reads[0] > 40) void'(reads.pop_front());
    exp = rest & ~model_low(cyc);
    chk(odt === exp, model_low(cyc) ? "R4/R5/R6/R7" : (rest ? "R8" : "R9"), odt, exp);
    if (must_low(cyc)) chk(odt === 1'b0, "R10", odt, 0);
  endtask

  task automatic set_cfg(input int al, input int cl, input int cwl);
    repeat (40) step(1'b0, 1'b1);
    reads.delete();
    cfg_al = CFG_W'(al); cfg_cl = CFG_W'(cl); cfg_cwl = CFG_W'(cwl);
    @(negedge clk);
    chk(int'(rl) == al + cl, "R1", rl, al + cl);
    chk(int'(odtl) == cwl + al - 2, "R2", odtl, cwl + al - 2);
  endtask

  task automatic lone_read();
    int d = int'(cfg_cl) - int'(cfg_cwl);
    step(1'b1, 1'b1);
    for (int k = 1; k <= d + 9; k++) step(1'b0, 1'b1);
    if (d + 7 > 0) chk(odt === 1'b1, "R6", odt, 1);
  endtask

  task automatic random_traffic(input int n);
    for (int k = 0; k < n; k++)
      step(($urandom % 4) == 0, ($urandom % 8) != 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    chk(odt === 1'b0, "R3", odt, 0);
    repeat (3) @(negedge clk);
    chk(odt === 1'b0, "R3", odt, 0);
    rst_n = 1'b1;

    set_cfg(5, 6, 5);
    chk(rl == 11 && odtl == 8, "R1/R2 example", {rl, odtl}, {6'd11, 6'd8});
    lone_read();
    for (int sp = 1; sp <= 8; sp++) begin
      step(1'b1, 1'b1);
      for (int k = 1; k < sp; k++) step(1'b0, 1'b1);
      step(1'b1, 1'b1);
      repeat (12) step(1'b0, 1'b1);
    end
    step(1'b1, 1'b0);
    repeat (12) step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    random_traffic(300);

    set_cfg(0, 7, 7);
    lone_read();
    random_traffic(200);

    set_cfg(0, 5, 7);
    lone_read();
    random_traffic(200);

    for (int t = 0; t < 12; t++) begin
      int cl  = 5 + ($urandom % 10);
      int cwl = 5 + ($urandom % 6);
      int al  = ($urandom % 3 == 0) ? 0 : cl - 1 - ($urandom % 2);
      set_cfg(al, cl, cwl);
      lone_read();
      random_traffic(250);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule